// File: doc/BRIEF.md
# Exception Acceptance and Return-Address Unit

This unit sits next to a simple in-order CPU pipeline. Each clock it looks at the pending exception, nonmaskable interrupt (NMI) and ordinary interrupt request lines and picks one outcome for each event:

- the event is accepted;
- the event is held pending;
- the event is turned into a forced manual reset.

The choice depends on the block bit of the status register and on whether the core is in a low-power mode.

When an event is accepted, the unit stores a return address and a copy of the status register. The return address depends on the event class:

- re-execution type exceptions;
- completion type exceptions and interrupts;
- either class when the event is tied to a delayed branch or to its delay slot.

The unit then issues a redirect to the handler vector.

The unit also carries out the restore step of a return-from-exception instruction. Every result is registered, so outputs change one clock after the inputs that cause them. The status register lives in this unit. The pipeline writes it through a plain write port, and all other status changes are made by the unit.

Top module: `exc_accept_unit`

## Requirements
- R1: An exception request that is not a user break, judged against a block bit of 1 (status bit 28), causes a forced reset one cycle later. `mreset_q` pulses, `evt_code_q` becomes 0x00000020, `new_pc_q` becomes the reset vector 0xA0000000 and the status register takes its reset value 0x700000F0. `spc_q` and `ssr_q` are left unchanged.
- R2: An ordinary interrupt that arrives while the block bit is 1, outside low-power mode, is not accepted and `irq_pend_q` is set. The interrupt is accepted in the first cycle that the registered status shows the block bit cleared.
- R3: An NMI that arrives while the block bit is 1 is held pending (`nmi_pend_q` set) when `nmi_hold` is 1, and accepted when `nmi_hold` is 0. An accepted NMI uses event code 0x000001C0.
- R4: With `lowpower` high, an NMI or ordinary interrupt is accepted even when the block bit is 1.
- R5: A re-execution type exception saves `cur_pc` in `spc_q`.
- R6: A re-execution type exception on a delay-slot instruction saves `br_pc`, the PC of the delayed branch, in `spc_q`. This holds whatever the outcome of the branch condition was.
- R7: A completion type exception or an interrupt saves `next_pc`. When the faulting instruction is a delayed branch, it saves `tgt_pc` instead.
- R8: Accepting an event does all of the following in one clock:
  - copies the status into `ssr_q`;
  - sets the block bit;
  - loads `evt_code_q` with `exc_code`, the NMI code or `irq_code`;
  - redirects `new_pc_q` to 0x80000100 for exceptions, or to 0x80000600 for NMI and interrupts;
  - pulses `taken_q`.
- R9: A return-from-exception loads `new_pc_q` from `spc_q` and the status register from `ssr_q`, with `new_pc_vld_q` high.
- R10: In the cycle after a return-from-exception, an instruction-fetch exception (`exc_fetch` high) is judged against the block bit as it was before the restore. Any other exception is judged against the restored status.
- R11: When several requests are active in one cycle, the order is forced reset, then exception, then NMI, then ordinary interrupt. All of them take precedence over the return and the status write.
- R12: A pending flag clears when its request line is withdrawn without being accepted.
- R13: A user-break exception with the block bit at 1 is accepted normally and does not cause a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request |
| exc_ubrk | input | 1 | Exception is a user break |
| exc_reexec | input | 1 | 1 = re-execution type, 0 = completion type |
| exc_fetch | input | 1 | Exception is tied to instruction fetch |
| exc_code | input | 32 | Event code of the exception |
| nmi_req | input | 1 | Nonmaskable interrupt request |
| nmi_hold | input | 1 | Hold NMI pending while block bit is 1 |
| irq_req | input | 1 | Ordinary interrupt request |
| irq_code | input | 32 | Event code of the interrupt |
| lowpower | input | 1 | Core is in sleep or standby |
| rte_exec | input | 1 | Return-from-exception executes |
| sr_wr_en | input | 1 | Status register write |
| sr_wr_data | input | 32 | Status write data |
| cur_pc | input | 32 | PC of the current instruction |
| next_pc | input | 32 | PC of the following instruction |
| tgt_pc | input | 32 | Branch destination |
| br_pc | input | 32 | PC of the delayed branch owning the slot |
| in_dslot | input | 1 | Current instruction is in a delay slot |
| is_dbranch | input | 1 | Current instruction is a delayed branch |
| sr_q | output | 32 | Status register |
| spc_q | output | 32 | Saved PC |
| ssr_q | output | 32 | Saved status |
| evt_code_q | output | 32 | Event code |
| new_pc_q | output | 32 | Redirect PC |
| new_pc_vld_q | output | 1 | Redirect valid |
| taken_q | output | 1 | Event accepted pulse |
| mreset_q | output | 1 | Forced reset pulse |
| irq_pend_q | output | 1 | Ordinary interrupt pending |
| nmi_pend_q | output | 1 | NMI pending |

## Verification
The hardest case to reach from the ports is the delay slot of a return instruction. In that slot the outcome depends on which status the exception is judged against, so the status before the restore and the status after it must differ. The stimulus first accepts an exception while the block bit is clear. This leaves the live status blocked and the saved status unblocked. A return is then issued, and in the very next cycle an exception is raised, once as a fetch exception and once as another kind. The fetch case must produce a forced reset and the other case a normal acceptance.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_RESET,
        EV_EXC,
        EV_NMI,
        EV_IRQ,
        EV_RTE,
        EV_SRWR
    } ev_kind_e;

    typedef struct packed {
        logic [31:0] sr;
        logic [31:0] spc;
        logic [31:0] ssr;
        logic [31:0] evt_code;
        logic [31:0] new_pc;
        logic        new_pc_vld;
        logic        taken;
        logic        mreset;
        logic        irq_pend;
        logic        nmi_pend;
        logic        rte_ds;
        logic        old_bl;
    } acc_state_t;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic     exc_req,
    input  logic     exc_ubrk,
    input  logic     exc_fetch,
    input  logic     nmi_req,
    input  logic     nmi_hold,
    input  logic     irq_req,
    input  logic     lowpower,
    input  logic     rte_exec,
    input  logic     sr_wr_en,
    input  logic     sr_bl,
    input  logic     old_bl,
    input  logic     rte_ds,
    output ev_kind_e kind
);

    logic bl_exc;
    logic nmi_ok;
    logic irq_ok;

    always_comb begin
        // A fetch exception in the return's slot is judged by the pre-restore block bit
        bl_exc = (rte_ds && exc_fetch) ? old_bl : sr_bl;
        nmi_ok = !sr_bl || !nmi_hold || lowpower;
        irq_ok = !sr_bl || lowpower;

        kind = EV_NONE;
        if (exc_req && bl_exc && !exc_ubrk) begin
            kind = EV_RESET;
        end else if (exc_req) begin
            kind = EV_EXC;
        end else if (nmi_req && nmi_ok) begin
            kind = EV_NMI;
        end else if (irq_req && irq_ok) begin
            kind = EV_IRQ;
        end else if (rte_exec) begin
            kind = EV_RTE;
        end else if (sr_wr_en) begin
            kind = EV_SRWR;
        end
    end

endmodule

// File: rtl/exc_retaddr.sv
module exc_retaddr #(
    parameter int AW = 32
) (
    input  logic          reexec,
    input  logic          in_dslot,
    input  logic          is_dbranch,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] tgt_pc,
    input  logic [AW-1:0] br_pc,
    output logic [AW-1:0] ret_pc
);

    always_comb begin
        if (reexec) begin
            ret_pc = in_dslot ? br_pc : cur_pc;
        end else begin
            ret_pc = is_dbranch ? tgt_pc : next_pc;
        end
    end

endmodule

// File: rtl/exc_accept_unit.sv
module exc_accept_unit
    import exc_pkg::*;
#(
    parameter int          BL_BIT    = 28,
    parameter logic [31:0] SR_RST    = 32'h7000_00F0,
    parameter logic [31:0] RST_CODE  = 32'h0000_0020,
    parameter logic [31:0] NMI_CODE  = 32'h0000_01C0,
    parameter logic [31:0] RESET_VEC = 32'hA000_0000,
    parameter logic [31:0] EXC_VEC   = 32'h8000_0100,
    parameter logic [31:0] INT_VEC   = 32'h8000_0600
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exc_req,
    input  logic        exc_ubrk,
    input  logic        exc_reexec,
    input  logic        exc_fetch,
    input  logic [31:0] exc_code,
    input  logic        nmi_req,
    input  logic        nmi_hold,
    input  logic        irq_req,
    input  logic [31:0] irq_code,
    input  logic        lowpower,
    input  logic        rte_exec,
    input  logic        sr_wr_en,
    input  logic [31:0] sr_wr_data,
    input  logic [31:0] cur_pc,
    input  logic [31:0] next_pc,
    input  logic [31:0] tgt_pc,
    input  logic [31:0] br_pc,
    input  logic        in_dslot,
    input  logic        is_dbranch,
    output logic [31:0] sr_q,
    output logic [31:0] spc_q,
    output logic [31:0] ssr_q,
    output logic [31:0] evt_code_q,
    output logic [31:0] new_pc_q,
    output logic        new_pc_vld_q,
    output logic        taken_q,
    output logic        mreset_q,
    output logic        irq_pend_q,
    output logic        nmi_pend_q
);

    localparam logic [31:0] BL_MASK = 32'h1 << BL_BIT;

    acc_state_t st_d;
    acc_state_t st_q;
    ev_kind_e   kind;
    logic       reexec_eff;
    logic [31:0] ret_pc;

    exc_arbiter u_arb (
        .exc_req   (exc_req),
        .exc_ubrk  (exc_ubrk),
        .exc_fetch (exc_fetch),
        .nmi_req   (nmi_req),
        .nmi_hold  (nmi_hold),
        .irq_req   (irq_req),
        .lowpower  (lowpower),
        .rte_exec  (rte_exec),
        .sr_wr_en  (sr_wr_en),
        .sr_bl     (st_q.sr[BL_BIT]),
        .old_bl    (st_q.old_bl),
        .rte_ds    (st_q.rte_ds),
        .kind      (kind)
    );

    // Interrupts are always completion type
    assign reexec_eff = (kind == EV_EXC) && exc_reexec;

    exc_retaddr #(.AW(32)) u_ret (
        .reexec     (reexec_eff),
        .in_dslot   (in_dslot),
        .is_dbranch (is_dbranch),
        .cur_pc     (cur_pc),
        .next_pc    (next_pc),
        .tgt_pc     (tgt_pc),
        .br_pc      (br_pc),
        .ret_pc     (ret_pc)
    );

    always_comb begin
        st_d            = st_q;
        st_d.taken      = 1'b0;
        st_d.mreset     = 1'b0;
        st_d.new_pc_vld = 1'b0;
        st_d.rte_ds     = 1'b0;
        st_d.irq_pend   = irq_req && (kind != EV_IRQ);
        st_d.nmi_pend   = nmi_req && (kind != EV_NMI);

        case (kind)
            EV_RESET: begin
                st_d.sr         = SR_RST;
                st_d.evt_code   = RST_CODE;
                st_d.new_pc     = RESET_VEC;
                st_d.new_pc_vld = 1'b1;
                st_d.mreset     = 1'b1;
            end
            EV_EXC, EV_NMI, EV_IRQ: begin
                st_d.spc        = ret_pc;
                st_d.ssr        = st_q.sr;
                st_d.sr         = st_q.sr | BL_MASK;
                st_d.new_pc     = (kind == EV_EXC) ? EXC_VEC : INT_VEC;
                st_d.new_pc_vld = 1'b1;
                st_d.taken      = 1'b1;
                if (kind == EV_EXC) begin
                    st_d.evt_code = exc_code;
                end else if (kind == EV_NMI) begin
                    st_d.evt_code = NMI_CODE;
                end else begin
                    st_d.evt_code = irq_code;
                end
            end
            EV_RTE: begin
                st_d.sr         = st_q.ssr;
                st_d.new_pc     = st_q.spc;
                st_d.new_pc_vld = 1'b1;
                st_d.rte_ds     = 1'b1;
                st_d.old_bl     = st_q.sr[BL_BIT];
            end
            EV_SRWR: begin
                st_d.sr = sr_wr_data;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.sr         <= SR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_q         = st_q.sr;
    assign spc_q        = st_q.spc;
    assign ssr_q        = st_q.ssr;
    assign evt_code_q   = st_q.evt_code;
    assign new_pc_q     = st_q.new_pc;
    assign new_pc_vld_q = st_q.new_pc_vld;
    assign taken_q      = st_q.taken;
    assign mreset_q     = st_q.mreset;
    assign irq_pend_q   = st_q.irq_pend;
    assign nmi_pend_q   = st_q.nmi_pend;

endmodule

// File: rtl/exc_accept_chk.sv
module exc_accept_chk #(
    parameter int BL_BIT = 28
) (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_req,
    input logic        nmi_req,
    input logic        irq_req,
    input logic        lowpower,
    input logic        rte_exec,
    input logic [31:0] sr_q,
    input logic [31:0] spc_q,
    input logic [31:0] ssr_q,
    input logic [31:0] evt_code_q,
    input logic [31:0] new_pc_q,
    input logic        taken_q,
    input logic        mreset_q
);

    AST_RESET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        mreset_q |-> (evt_code_q == 32'h20 && !taken_q)); // R1

    AST_RESET_KEEPS_SPC: assert property (@(posedge clk) disable iff (!rst_n)
        mreset_q |-> $stable(spc_q)); // R1

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !exc_req && !nmi_req && sr_q[BL_BIT] && !lowpower) |=> !taken_q); // R2

    AST_LOWPOWER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpower && irq_req && !exc_req) |=> taken_q); // R4

    AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        taken_q |-> sr_q[BL_BIT]); // R8

    AST_TAKE_SAVES_SR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(taken_q) |-> (ssr_q == $past(sr_q))); // R8

    AST_RTE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_exec && !exc_req && !nmi_req && !irq_req)
            |=> (new_pc_q == $past(spc_q) && sr_q == $past(ssr_q))); // R9

endmodule

bind exc_accept_unit exc_accept_chk #(.BL_BIT(BL_BIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_req    (exc_req),
    .nmi_req    (nmi_req),
    .irq_req    (irq_req),
    .lowpower   (lowpower),
    .rte_exec   (rte_exec),
    .sr_q       (sr_q),
    .spc_q      (spc_q),
    .ssr_q      (ssr_q),
    .evt_code_q (evt_code_q),
    .new_pc_q   (new_pc_q),
    .taken_q    (taken_q),
    .mreset_q   (mreset_q)
);

// File: tb/test_exc_accept_unit.sv
`timescale 1ns/1ps
module test_exc_accept_unit;

    localparam logic [31:0] SR_RST    = 32'h7000_00F0;
    localparam logic [31:0] SR_OPEN   = 32'h0000_00F0;
    localparam logic [31:0] SR_BLK    = 32'h1000_00F0;
    localparam logic [31:0] RESET_VEC = 32'hA000_0000;
    localparam logic [31:0] EXC_VEC   = 32'h8000_0100;
    localparam logic [31:0] INT_VEC   = 32'h8000_0600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req, exc_ubrk, exc_reexec, exc_fetch;
    logic [31:0] exc_code;
    logic        nmi_req, nmi_hold, irq_req;
    logic [31:0] irq_code;
    logic        lowpower, rte_exec, sr_wr_en;
    logic [31:0] sr_wr_data, cur_pc, next_pc, tgt_pc, br_pc;
    logic        in_dslot, is_dbranch;
    logic [31:0] sr_q, spc_q, ssr_q, evt_code_q, new_pc_q;
    logic        new_pc_vld_q, taken_q, mreset_q, irq_pend_q, nmi_pend_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_accept_unit i_exc_accept_unit (
        .clk(clk), .rst_n(rst_n),
        .exc_req(exc_req), .exc_ubrk(exc_ubrk), .exc_reexec(exc_reexec),
        .exc_fetch(exc_fetch), .exc_code(exc_code),
        .nmi_req(nmi_req), .nmi_hold(nmi_hold), .irq_req(irq_req), .irq_code(irq_code),
        .lowpower(lowpower), .rte_exec(rte_exec), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .cur_pc(cur_pc), .next_pc(next_pc), .tgt_pc(tgt_pc), .br_pc(br_pc),
        .in_dslot(in_dslot), .is_dbranch(is_dbranch),
        .sr_q(sr_q), .spc_q(spc_q), .ssr_q(ssr_q), .evt_code_q(evt_code_q),
        .new_pc_q(new_pc_q), .new_pc_vld_q(new_pc_vld_q), .taken_q(taken_q),
        .mreset_q(mreset_q), .irq_pend_q(irq_pend_q), .nmi_pend_q(nmi_pend_q)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        exc_req = 0; exc_ubrk = 0; exc_reexec = 0; exc_fetch = 0; exc_code = 0;
        nmi_req = 0; nmi_hold = 0; irq_req = 0; irq_code = 0; lowpower = 0;
        rte_exec = 0; sr_wr_en = 0; sr_wr_data = 0;
        cur_pc = 0; next_pc = 0; tgt_pc = 0; br_pc = 0; in_dslot = 0; is_dbranch = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_sr(input logic [31:0] v);
        sr_wr_en = 1; sr_wr_data = v; step(); sr_wr_en = 0;
    endtask

    task automatic take_exc(input logic [31:0] pc, input logic [31:0] code);
        exc_req = 1; exc_reexec = 1; cur_pc = pc; exc_code = code;
        step(); idle();
    endtask

    task automatic t_reset_state();
        chk("R1", "reset sr", sr_q, SR_RST);
        chk("R8", "reset taken", {31'b0, taken_q}, 0);
        chk("R2", "reset irq pend", {31'b0, irq_pend_q}, 0);
    endtask

    task automatic t_forced_reset();
        exc_req = 1; exc_reexec = 1; cur_pc = 32'h100; exc_code = 32'h0E0;
        step(); idle();
        chk("R1", "mreset", {31'b0, mreset_q}, 1);
        chk("R1", "code", evt_code_q, 32'h20);
        chk("R1", "new pc", new_pc_q, RESET_VEC);
        chk("R1", "spc kept", spc_q, 0);
        chk("R1", "sr", sr_q, SR_RST);
    endtask

    task automatic t_user_break();
        exc_req = 1; exc_ubrk = 1; exc_reexec = 1; cur_pc = 32'h200; exc_code = 32'h1E0;
        step(); idle();
        chk("R13", "taken", {31'b0, taken_q}, 1);
        chk("R13", "mreset", {31'b0, mreset_q}, 0);
        chk("R13", "spc", spc_q, 32'h200);
        chk("R13", "code", evt_code_q, 32'h1E0);
    endtask

    task automatic t_ret_addr();
        set_sr(SR_OPEN);
        take_exc(32'h1000, 32'h0A0);
        chk("R5", "spc reexec", spc_q, 32'h1000);
        chk("R8", "ssr", ssr_q, SR_OPEN);
        chk("R8", "sr blocked", sr_q, SR_BLK);
        chk("R8", "vector", new_pc_q, EXC_VEC);
        set_sr(SR_OPEN);
        exc_req = 1; exc_reexec = 1; in_dslot = 1; br_pc = 32'h2000; cur_pc = 32'h2002;
        step(); idle();
        chk("R6", "spc dslot", spc_q, 32'h2000);
        set_sr(SR_OPEN);
        exc_req = 1; cur_pc = 32'h3000; next_pc = 32'h3004; tgt_pc = 32'h9000;
        step(); idle();
        chk("R7", "spc completion", spc_q, 32'h3004);
        set_sr(SR_OPEN);
        exc_req = 1; is_dbranch = 1; cur_pc = 32'h3000; next_pc = 32'h3004; tgt_pc = 32'h4000;
        step(); idle();
        chk("R7", "spc branch target", spc_q, 32'h4000);
    endtask

    task automatic t_irq_held();
        // block bit is 1 here
        irq_req = 1; irq_code = 32'h400; next_pc = 32'h6004;
        step();
        chk("R2", "irq not taken", {31'b0, taken_q}, 0);
        chk("R2", "irq pending", {31'b0, irq_pend_q}, 1);
        sr_wr_en = 1; sr_wr_data = SR_OPEN;
        step();
        sr_wr_en = 0;
        chk("R2", "not taken during clear", {31'b0, taken_q}, 0);
        step();
        chk("R2", "taken after clear", {31'b0, taken_q}, 1);
        chk("R8", "irq code", evt_code_q, 32'h400);
        chk("R8", "irq vector", new_pc_q, INT_VEC);
        chk("R7", "irq spc", spc_q, 32'h6004);
        chk("R2", "pend cleared", {31'b0, irq_pend_q}, 0);
        idle();
        step();
        irq_req = 1; irq_code = 32'h420;
        step();
        step();
        chk("R12", "pend while held", {31'b0, irq_pend_q}, 1);
        irq_req = 0;
        step();
        chk("R12", "pend after withdraw", {31'b0, irq_pend_q}, 0);
        idle();
    endtask

    task automatic t_lowpower_nmi();
        lowpower = 1; irq_req = 1; irq_code = 32'h440;
        step(); idle();
        chk("R4", "lowpower irq taken", {31'b0, taken_q}, 1);
        chk("R4", "lowpower code", evt_code_q, 32'h440);
        nmi_req = 1; nmi_hold = 1;
        step();
        chk("R3", "nmi held", {31'b0, taken_q}, 0);
        chk("R3", "nmi pending", {31'b0, nmi_pend_q}, 1);
        nmi_hold = 0;
        step(); idle();
        chk("R3", "nmi accepted", {31'b0, taken_q}, 1);
        chk("R3", "nmi code", evt_code_q, 32'h1C0);
    endtask

    task automatic t_priority();
        set_sr(SR_OPEN);
        exc_req = 1; exc_code = 32'h0A0; nmi_req = 1; irq_req = 1; irq_code = 32'h400;
        step(); idle();
        chk("R11", "exc over nmi", evt_code_q, 32'h0A0);
        set_sr(SR_OPEN);
        nmi_req = 1; irq_req = 1; irq_code = 32'h400;
        step(); idle();
        chk("R11", "nmi over irq", evt_code_q, 32'h1C0);
        exc_req = 1; exc_code = 32'h0A0; nmi_req = 1; irq_req = 1;
        step(); idle();
        chk("R11", "reset first", {31'b0, mreset_q}, 1);
    endtask

    task automatic t_rte();
        set_sr(SR_OPEN);
        take_exc(32'h5000, 32'h0A0);
        rte_exec = 1;
        step(); idle();
        chk("R9", "rte pc", new_pc_q, 32'h5000);
        chk("R9", "rte valid", {31'b0, new_pc_vld_q}, 1);
        chk("R9", "rte sr", sr_q, SR_OPEN);
        set_sr(SR_OPEN);
        take_exc(32'h5100, 32'h0A0);
        rte_exec = 1;
        step(); idle();
        exc_req = 1; exc_fetch = 1; exc_code = 32'h0E0;
        step(); idle();
        chk("R10", "fetch exc in slot resets", {31'b0, mreset_q}, 1);
        set_sr(SR_OPEN);
        take_exc(32'h5200, 32'h0A0);
        rte_exec = 1;
        step(); idle();
        exc_req = 1; exc_code = 32'h0E0;
        step(); idle();
        chk("R10", "other exc in slot taken", {31'b0, taken_q}, 1);
        chk("R10", "other exc code", evt_code_q, 32'h0E0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset_state();
        t_forced_reset();
        t_user_break();
        t_ret_addr();
        t_irq_held();
        set_sr(SR_BLK);
        t_lowpower_nmi();
        t_priority();
        t_rte();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule